// File: doc/BRIEF.md
# Dual-Lane Packed Saturation Unit

This block treats a 32-bit word as two independent 16-bit lanes and clamps each lane to a range set by a run-time bit position. In signed mode each lane is read as a two's-complement value and limited to a signed range of that width. In unsigned mode the lane is still read as signed, but it is limited to a non-negative range of that width. The two clamped lanes are packed back into the positions they came from. The result is registered and arrives one clock after an accepted request.

The unit sits behind an issue stage. A request is accepted only when the valid strobe and the execute-enable are both high. When execute-enable is low the request is dropped with no trace. A sticky saturation flag records that a lane was limited by any accepted operation since the last clear. An out-of-range bit position is reported on a separate output, and the operand then passes through untouched.

Top module: `pack_sat_unit`

## Requirements
- R1: The two 16-bit lanes (bits 15:0 and 31:16) are clamped independently. Each result is written back to the lane position it came from, so clamping one lane never alters the other.
- R2: With `mode_uns`=0, legal `sat_pos` values are 1 to 16. Each lane is clamped to the range -2^(n-1) to 2^(n-1)-1. For example, n=9 gives -256 to 255, and n=16 never clamps.
- R3: With `mode_uns`=1, legal `sat_pos` values are 0 to 15. Each lane is read as signed and clamped to the range 0 to 2^n-1. For example, n=13 gives 0 to 8191, and n=0 forces every lane to 0.
- R4: A lane already inside the range, including one exactly equal to a bound, passes unchanged and does not count as saturated.
- R5: When an accepted legal operation clamps either lane, `sat_flag` is set to 1 at the same edge the result is registered. It stays at 1 over later operations that do not saturate.
- R6: A high `flag_clr` clears `sat_flag` at the next edge. If the same cycle also carries a saturating accepted operation, the flag ends at 1.
- R7: When `in_valid` or `exec_en` is low, `out_valid` is 0 at the next edge, `out_data` holds its previous value and `sat_flag` is not changed by the request.
- R8: An illegal `sat_pos` is one of: 0 or 17 to 31 in signed mode, or 16 to 31 in unsigned mode. For an illegal value, `bad_pos` is 1 together with `out_valid`, `out_data` equals the operand, and `sat_flag` is not set. `bad_pos` is 0 whenever `out_valid` is 0.
- R9: `out_valid` is 1 exactly one clock after a cycle with `in_valid` and `exec_en` both high, and 0 otherwise.
- R10: After a synchronous reset, `out_valid`, `out_data`, `sat_flag` and `bad_pos` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| exec_en | input | 1 | Condition result; request is dropped when 0 |
| mode_uns | input | 1 | 0 = signed range, 1 = unsigned range |
| sat_pos | input | 5 | Bit position n |
| operand | input | 32 | Two packed 16-bit lanes |
| flag_clr | input | 1 | Clears the sticky flag |
| out_valid | output | 1 | Result strobe, one clock after acceptance |
| out_data | output | 32 | Packed clamped lanes |
| sat_flag | output | 1 | Sticky saturation flag |
| bad_pos | output | 1 | Illegal bit position for the chosen mode |

## Verification
The assertions assume that `mode_uns`, `sat_pos` and `operand` are sampled only at the edge where a request is accepted. They also assume that the reset lasts at least one edge before the first request. The stimulus drives every input on the falling edge and returns `in_valid` to 0 between operations. Because of this, each `$past` reference in a check points at exactly one request. The sweep covers every 5-bit position in both modes, including the illegal ones, and pairs lanes so that either lane, both lanes or neither lane saturates.

// File: rtl/pack_sat_pkg.sv
package pack_sat_pkg;
  typedef enum logic {
    RANGE_SIGNED   = 1'b0,
    RANGE_UNSIGNED = 1'b1
  } range_mode_e;
endpackage

// File: rtl/pack_sat_pos_check.sv
module pack_sat_pos_check
  import pack_sat_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int POS_W  = 5
) (
  input  range_mode_e       mode,
  input  logic [POS_W-1:0]  sat_pos,
  output logic              legal
);
  localparam int MAX_SIGNED   = LANE_W;
  localparam int MAX_UNSIGNED = LANE_W - 1;

  always_comb begin
    if (mode == RANGE_UNSIGNED)
      legal = (32'(sat_pos) <= MAX_UNSIGNED);
    else
      legal = (sat_pos != '0) && (32'(sat_pos) <= MAX_SIGNED);
  end
endmodule

// File: rtl/pack_sat_lane.sv
module pack_sat_lane
  import pack_sat_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int POS_W  = 5
) (
  input  logic [LANE_W-1:0] lane_in,
  input  range_mode_e       mode,
  input  logic [POS_W-1:0]  sat_pos,
  output logic [LANE_W-1:0] lane_out,
  output logic              clamped
);
  localparam int EW = LANE_W + 2;

  logic signed [EW-1:0] x_ext;
  logic signed [EW-1:0] hi_b;
  logic signed [EW-1:0] lo_b;
  logic        [POS_W-1:0] shamt;
  logic        [EW-1:0] pow2;

  always_comb begin
    x_ext = EW'($signed(lane_in));
    shamt = (mode == RANGE_UNSIGNED) ? sat_pos : (sat_pos - POS_W'(1));
    pow2  = EW'(1) << shamt;
    hi_b  = $signed(pow2 - EW'(1));
    if (mode == RANGE_UNSIGNED)
      lo_b = '0;
    else
      lo_b = $signed(EW'(0) - pow2);

    if (x_ext > hi_b) begin
      lane_out = hi_b[LANE_W-1:0];
      clamped  = 1'b1;
    end else if (x_ext < lo_b) begin
      lane_out = lo_b[LANE_W-1:0];
      clamped  = 1'b1;
    end else begin
      lane_out = lane_in;
      clamped  = 1'b0;
    end
  end
endmodule

// File: rtl/pack_sat_unit.sv
module pack_sat_unit
  import pack_sat_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 2,
  parameter int POS_W  = $clog2(LANE_W) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    exec_en,
  input  logic                    mode_uns,
  input  logic [POS_W-1:0]        sat_pos,
  input  logic [LANE_W*LANES-1:0] operand,
  input  logic                    flag_clr,
  output logic                    out_valid,
  output logic [LANE_W*LANES-1:0] out_data,
  output logic                    sat_flag,
  output logic                    bad_pos
);
  localparam int DW = LANE_W * LANES;

  range_mode_e    mode;
  logic           pos_ok;
  logic           fire;
  logic [DW-1:0]  packed_res;
  logic [LANES-1:0] lane_hit;

  assign mode = range_mode_e'(mode_uns);
  assign fire = in_valid & exec_en;

  pack_sat_pos_check #(.LANE_W(LANE_W), .POS_W(POS_W)) u_pos (
    .mode    (mode),
    .sat_pos (sat_pos),
    .legal   (pos_ok)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pack_sat_lane #(.LANE_W(LANE_W), .POS_W(POS_W)) u_lane (
      .lane_in  (operand[g*LANE_W +: LANE_W]),
      .mode     (mode),
      .sat_pos  (sat_pos),
      .lane_out (packed_res[g*LANE_W +: LANE_W]),
      .clamped  (lane_hit[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      bad_pos   <= 1'b0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= fire;
      bad_pos   <= fire & ~pos_ok;
      if (fire)
        out_data <= pos_ok ? packed_res : operand;
      if (fire && pos_ok && (|lane_hit))
        sat_flag <= 1'b1;
      else if (flag_clr)
        sat_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pack_sat_chk.sv
module pack_sat_chk #(
  parameter int LANE_W = 16,
  parameter int LANES  = 2,
  parameter int POS_W  = 5
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    exec_en,
  input logic                    mode_uns,
  input logic [POS_W-1:0]        sat_pos,
  input logic [LANE_W*LANES-1:0] operand,
  input logic                    flag_clr,
  input logic                    out_valid,
  input logic [LANE_W*LANES-1:0] out_data,
  input logic                    sat_flag,
  input logic                    bad_pos
);
  assert_valid_source_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && exec_en));

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid && exec_en) && !$past(rst)) |-> out_valid);

  assert_flag_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid && exec_en) && !$past(flag_clr)) |-> $stable(sat_flag));

  assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid && exec_en)) |-> $stable(out_data));

  assert_clear_works_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flag_clr) && !$past(in_valid && exec_en)) |-> !sat_flag);

  assert_bad_passthru_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && bad_pos) |-> (out_data == $past(operand)));

  assert_bad_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && bad_pos && !$past(sat_flag)) |-> !sat_flag);

  assert_bad_gated_R8: assert property (@(posedge clk) disable iff (rst)
    bad_pos |-> out_valid);

  for (genvar g = 0; g < LANES; g++) begin : g_rng
    assert_uns_range_R3: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !bad_pos && $past(mode_uns)) |->
        ((LANE_W+1)'(out_data[g*LANE_W +: LANE_W]) < ((LANE_W+1)'(1) << $past(sat_pos))));
  end
endmodule

bind pack_sat_unit pack_sat_chk #(.LANE_W(LANE_W), .LANES(LANES), .POS_W(POS_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .exec_en(exec_en), .mode_uns(mode_uns),
  .sat_pos(sat_pos), .operand(operand), .flag_clr(flag_clr), .out_valid(out_valid),
  .out_data(out_data), .sat_flag(sat_flag), .bad_pos(bad_pos)
);

// File: tb/pack_sat_unit_bench.sv
module pack_sat_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, exec_en, mode_uns, flag_clr;
  logic [4:0]  sat_pos;
  logic [31:0] operand;
  logic        out_valid, sat_flag, bad_pos;
  logic [31:0] out_data;

  int checks = 0;
  int failures = 0;
  bit model_flag = 1'b0;
  logic [31:0] model_data = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pack_sat_unit u_pack_sat_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .exec_en(exec_en), .mode_uns(mode_uns),
    .sat_pos(sat_pos), .operand(operand), .flag_clr(flag_clr), .out_valid(out_valid),
    .out_data(out_data), .sat_flag(sat_flag), .bad_pos(bad_pos)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit legal_pos(input bit uns, input int n);
    if (uns) return n <= 15;
    return (n >= 1) && (n <= 16);
  endfunction

  function automatic logic [15:0] clamp16(input logic [15:0] v, input bit uns, input int n, output bit hit);
    int x, hi, lo;
    x = int'($signed(v));
    if (uns) begin hi = (1 << n) - 1; lo = 0; end
    else begin hi = (1 << (n - 1)) - 1; lo = -(1 << (n - 1)); end
    hit = 1'b0;
    if (x > hi) begin hit = 1'b1; return 16'(hi); end
    if (x < lo) begin hit = 1'b1; return 16'(lo); end
    return v;
  endfunction

  // Drives one cycle, then checks every output at the next falling edge.
  task automatic step(input logic [15:0] a_hi, input logic [15:0] a_lo, input bit uns,
                      input int n, input bit vld, input bit ex, input bit clr, input string tag);
    bit h0, h1, ok_pos, fire;
    logic [31:0] exp_d;
    ok_pos = legal_pos(uns, n);
    fire = vld && ex;
    exp_d = {clamp16(a_hi, uns, n, h1), clamp16(a_lo, uns, n, h0)};
    in_valid = vld; exec_en = ex; mode_uns = uns; sat_pos = 5'(n);
    operand = {a_hi, a_lo}; flag_clr = clr;
    @(negedge clk);
    if (fire) model_data = ok_pos ? exp_d : {a_hi, a_lo};
    if (fire && ok_pos && (h0 || h1)) model_flag = 1'b1;
    else if (clr) model_flag = 1'b0;
    check(out_valid == fire, "R9 out_valid", 64'(out_valid), 64'(fire));
    check(out_data == model_data, tag, 64'(out_data), 64'(model_data));
    check(bad_pos == (fire && !ok_pos), "R8 bad_pos", 64'(bad_pos), 64'(fire && !ok_pos));
    check(sat_flag == model_flag, "R5/R6 sat_flag", 64'(sat_flag), 64'(model_flag));
    in_valid = 1'b0; exec_en = 1'b0; flag_clr = 1'b0;
  endtask

  initial begin
    logic [15:0] vals [12];
    int k;
    vals = '{16'h8000, 16'h7FFF, 16'h0000, 16'h0001, 16'hFFFF, 16'h00FF,
             16'h0100, 16'hFF00, 16'hFEFF, 16'h1FFF, 16'h2000, 16'hC123};
    rst = 1'b1; in_valid = 0; exec_en = 0; mode_uns = 0; sat_pos = 0; operand = 0; flag_clr = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_data == 0 && sat_flag == 0 && bad_pos == 0, "R10 reset",
          {out_valid, sat_flag, bad_pos, out_data}, 64'd0);
    rst = 1'b0;

    // R4: exact bounds in signed n=9 do not saturate
    step(16'h00FF, 16'hFF00, 1'b0, 9, 1, 1, 0, "R4 bound pass");
    step(16'h00FF, 16'hFF00, 1'b0, 9, 1, 1, 0, "R4 bound pass");
    check(sat_flag == 0, "R4 no flag at bound", 64'(sat_flag), 64'd0);
    // R1: only upper lane saturates, lower untouched
    step(16'h7FFF, 16'h0012, 1'b1, 13, 1, 1, 0, "R1 one lane");
    check(out_data == 32'h1FFF_0012, "R1 lanes", 64'(out_data), 64'h1FFF0012);
    // R7: dropped request with saturating operand, flag cleared first
    step(16'h0, 16'h0, 1'b0, 16, 0, 0, 1, "R6 clear");
    check(sat_flag == 0, "R6 cleared", 64'(sat_flag), 64'd0);
    step(16'h8000, 16'h7FFF, 1'b0, 4, 1, 0, 0, "R7 exec off");
    check(sat_flag == 0 && out_data == 32'h1FFF_0012, "R7 nothing written",
          {sat_flag, out_data}, 64'h1FFF0012);
    // R6: saturation wins over clear in the same cycle
    step(16'h8000, 16'h0000, 1'b0, 2, 1, 1, 1, "R6 set wins");
    check(sat_flag == 1, "R6 set wins", 64'(sat_flag), 64'd1);
    // R3: n=0 zeros everything
    step(16'h0000, 16'h0000, 1'b1, 0, 1, 1, 1, "R3 n0 zero");
    step(16'h1234, 16'h8000, 1'b1, 0, 1, 1, 0, "R3 n0 clamp");
    check(out_data == 0, "R3 n0 output", 64'(out_data), 64'd0);
    // R8: illegal positions pass operand
    step(16'h8000, 16'h7FFF, 1'b0, 0, 1, 1, 1, "R8 illegal signed");
    step(16'h8000, 16'h7FFF, 1'b1, 16, 1, 1, 0, "R8 illegal unsigned");

    // Sweep of all positions in both modes, with R2 / R3 expectations
    k = 0;
    for (int m = 0; m < 2; m++)
      for (int n = 0; n < 32; n++)
        for (int i = 0; i < 12; i++)
          for (int j = 0; j < 12; j++) begin
            k++;
            step(vals[i], vals[j], m[0], n, 1, ((k % 7) != 0), ((k % 3) == 0),
                 (m == 1) ? "R3 unsigned sweep" : "R2 signed sweep");
          end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule